// File: doc/BRIEF.md
# Split-Carry Sequential PC Step Unit

This block produces the address of the next sequential instruction in a fetch stage. It takes the current program counter and two decode flags. One flag says that a register-specifier byte follows the opcode. The other says that a four-byte constant follows. From these it forms the instruction length and adds it to the program counter.

The addition is split at bit 3. A narrow adder adds the length to the low three bits. At the same time, a separate incrementer adds one to the upper field, using only the program counter. The carry out of the narrow adder then picks either the upper field or its incremented copy. The instruction length therefore never reaches the long carry chain. The path is combinational. A one-stage output register with a valid flag holds the result for the surrounding pipeline.

Top module: `pc_step_unit`

## Requirements
- R1: The instruction length is 1 byte, plus 1 when `has_reg_byte` is high, plus 4 when `has_const_word` is high, so it takes only the values 1, 2, 5 or 6.
- R2: Bits [2:0] of `next_pc` equal (`pc_in[2:0]` + length) modulo 8.
- R3: Bits [31:3] of `next_pc` equal `pc_in[31:3]` + 1 when the low 3-bit sum overflows. Otherwise they equal `pc_in[31:3]` unchanged.
- R4: When `pc_in[31:3]` is all ones and the low sum overflows, bits [31:3] of `next_pc` wrap to zero.
- R5: `out_valid` is high exactly in the cycle after a clock edge at which `in_valid` was high. The result for that input appears on `next_pc` in that same cycle.
- R6: While `rst_n` is low at a clock edge, `out_valid` and `next_pc` are cleared to zero.
- R7: A clock edge with `in_valid` low leaves `next_pc` unchanged.
- R8: Every accepted input yields `next_pc` = `pc_in` + length, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The inputs on this edge are to be processed |
| pc_in | input | 32 | Current program counter |
| has_reg_byte | input | 1 | A register-specifier byte follows the opcode |
| has_const_word | input | 1 | A four-byte constant follows |
| out_valid | output | 1 | `next_pc` holds a fresh result |
| next_pc | output | 32 | Registered sequential next program counter |

## Verification
The overflow of the narrow low adder and the wrap of the upper incrementer can happen in the same cycle. The incremented upper field is then both selected and rolled over to zero. The bench provokes this with program counters whose upper 29 bits are all ones and whose low bits lie between 2 and 7. It applies all four flag combinations to each of these. Each result is judged against a plain 32-bit sum of the program counter and the length. Any mismatch in the upper field is reported against the wrap requirement.

// File: rtl/pcinc_pkg.sv
// Package pcinc_pkg
// Shared types for the PC step unit.
// Assumes the decode stage supplies both length flags together.
package pcinc_pkg;

    // Decode flags that set the instruction length
    typedef struct packed {
        logic reg_byte;    // one register-specifier byte follows
        logic const_word;  // one four-byte constant follows
    } len_flags_t;

    localparam int unsigned BASE_BYTES  = 1;
    localparam int unsigned REG_BYTES   = 1;
    localparam int unsigned CONST_BYTES = 4;

endpackage

// File: rtl/pcinc_len_enc.sv
// Module pcinc_len_enc
// Turns the decode flags into an instruction length in bytes.
// Assumes LOW_W is wide enough to hold the largest length (6 needs 3 bits).
module pcinc_len_enc
    import pcinc_pkg::*;
#(
    parameter int unsigned LOW_W = 3
) (
    input  len_flags_t       flags,
    output logic [LOW_W-1:0] len
);

    // Sum the base byte and the optional trailing fields
    always_comb begin
        len = LOW_W'(BASE_BYTES);
        if (flags.reg_byte)   len = len + LOW_W'(REG_BYTES);
        if (flags.const_word) len = len + LOW_W'(CONST_BYTES);
    end

endmodule

// File: rtl/pcinc_low_add.sv
// Module pcinc_low_add
// Narrow adder for the low field of the PC. It reports the carry out.
// Assumes both operands share the width LOW_W.
module pcinc_low_add #(
    parameter int unsigned LOW_W = 3
) (
    input  logic [LOW_W-1:0] a,
    input  logic [LOW_W-1:0] b,
    output logic [LOW_W-1:0] sum,
    output logic             carry
);

    // Add with one extra bit so the overflow shows as the carry
    always_comb begin
        {carry, sum} = {1'b0, a} + {1'b0, b};
    end

endmodule

// File: rtl/pcinc_hi_inc.sv
// Module pcinc_hi_inc
// Speculative incrementer for the upper PC field. It uses only the PC, so
// it runs in parallel with the length decode. Built as a ripple of
// half-adders produced by generate. Assumes HI_W >= 1.
module pcinc_hi_inc #(
    parameter int unsigned HI_W = 29
) (
    input  logic [HI_W-1:0] hi,
    output logic [HI_W-1:0] hi_plus1
);

    logic [HI_W:0] cy;

    assign cy[0] = 1'b1;

    // One half-adder per bit of the upper field
    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        assign hi_plus1[i] = hi[i] ^ cy[i];
        assign cy[i+1]     = hi[i] & cy[i];
    end

endmodule

// File: rtl/pcinc_hi_sel.sv
// Module pcinc_hi_sel
// Late 2:1 select of the upper field, driven by the low-adder carry.
// Assumes both candidates are valid when the carry settles.
module pcinc_hi_sel #(
    parameter int unsigned HI_W = 29
) (
    input  logic            carry,
    input  logic [HI_W-1:0] hi_same,
    input  logic [HI_W-1:0] hi_plus1,
    output logic [HI_W-1:0] hi_out
);

    // Carry picks the incremented copy, otherwise pass the original
    always_comb begin
        hi_out = carry ? hi_plus1 : hi_same;
    end

endmodule

// File: rtl/pc_step_unit.sv
// Module pc_step_unit
// Sequential next-PC unit. A combinational split-carry path feeds a
// one-stage output register.
// Assumes ADDR_W > LOW_W and that the largest length fits in LOW_W bits.
module pc_step_unit
    import pcinc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              has_reg_byte,
    input  logic              has_const_word,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_pc
);

    localparam int unsigned HI_W = ADDR_W - LOW_W;

    len_flags_t       flags;
    logic [LOW_W-1:0] len;
    logic [LOW_W-1:0] low_sum;
    logic             low_carry;
    logic [HI_W-1:0]  hi_plus1;
    logic [HI_W-1:0]  hi_res;

    assign flags.reg_byte   = has_reg_byte;
    assign flags.const_word = has_const_word;

    pcinc_len_enc #(.LOW_W(LOW_W)) u_len (
        .flags (flags),
        .len   (len)
    );

    pcinc_low_add #(.LOW_W(LOW_W)) u_low (
        .a     (pc_in[LOW_W-1:0]),
        .b     (len),
        .sum   (low_sum),
        .carry (low_carry)
    );

    pcinc_hi_inc #(.HI_W(HI_W)) u_inc (
        .hi       (pc_in[ADDR_W-1:LOW_W]),
        .hi_plus1 (hi_plus1)
    );

    pcinc_hi_sel #(.HI_W(HI_W)) u_sel (
        .carry    (low_carry),
        .hi_same  (pc_in[ADDR_W-1:LOW_W]),
        .hi_plus1 (hi_plus1),
        .hi_out   (hi_res)
    );

    // Register the result and its valid flag; hold the value when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) next_pc <= {hi_res, low_sum};
        end
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (len == LOW_W'(1) || len == LOW_W'(2) ||
                      len == LOW_W'(5) || len == LOW_W'(6))); // R1

    AST_LOW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> next_pc[LOW_W-1:0] ==
                     LOW_W'($past(pc_in[LOW_W-1:0]) + $past(len))); // R2

    AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !low_carry) |=>
            next_pc[ADDR_W-1:LOW_W] == $past(pc_in[ADDR_W-1:LOW_W])); // R3

    AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && low_carry) |=>
            next_pc[ADDR_W-1:LOW_W] == HI_W'($past(pc_in[ADDR_W-1:LOW_W]) + 1'b1)); // R3

    AST_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && low_carry && (&pc_in[ADDR_W-1:LOW_W])) |=>
            next_pc[ADDR_W-1:LOW_W] == '0); // R4

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(next_pc)); // R7

    AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> next_pc == ADDR_W'($past(pc_in) + ADDR_W'($past(len)))); // R8

endmodule

// File: tb/tb_pc_step_unit.sv
module tb_pc_step_unit;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WATCHDOG   = 100000;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc_in = '0;
    logic        has_reg_byte = 1'b0;
    logic        has_const_word = 1'b0;
    logic        out_valid;
    logic [31:0] next_pc;

    int total = 0;
    int bad = 0;
    item_t sb[$];
    logic        ref_valid = 1'b0;
    logic [31:0] last_pc = '0;
    bit          done = 1'b0;

    pc_step_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .pc_in          (pc_in),
        .has_reg_byte   (has_reg_byte),
        .has_const_word (has_const_word),
        .out_valid      (out_valid),
        .next_pc        (next_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side valid pipeline, R5 reference
    always @(posedge clk) ref_valid <= rst_n ? in_valid : 1'b0;

    // Driver: apply one input at a negedge and push its expected result
    task automatic send(input logic [31:0] pc, input bit r, input bit c, input string tag);
        item_t it;
        @(negedge clk);
        in_valid       = 1'b1;
        pc_in          = pc;
        has_reg_byte   = r;
        has_const_word = c;
        it.exp = pc + 32'(1 + (r ? 1 : 0) + (c ? 4 : 0));
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            pc_in    = $urandom;   // must be ignored while idle (R7)
        end
    endtask

    // Monitor: compare against the scoreboard between clock edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (out_valid !== ref_valid) begin
                bad++;
                $display("FAIL R5 out_valid actual=%0b expected=%0b", out_valid, ref_valid);
            end
            if (out_valid) begin
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R5 unexpected result actual=%h expected=none", next_pc);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    total++;
                    if (next_pc !== it.exp) begin
                        bad++;
                        if (next_pc[2:0] !== it.exp[2:0])
                            $display("FAIL R2 (%s) actual=%h expected=%h", it.tag, next_pc, it.exp);
                        else
                            $display("FAIL %s actual=%h expected=%h", it.tag, next_pc, it.exp);
                    end
                    last_pc = next_pc;
                end
            end else begin
                total++;
                if (next_pc !== last_pc) begin
                    bad++;
                    $display("FAIL R7 held value actual=%h expected=%h", next_pc, last_pc);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || next_pc !== 32'h0) begin
            bad++;
            $display("FAIL R6 reset actual=%b/%h expected=0/00000000", out_valid, next_pc);
        end
        rst_n = 1'b1;

        // R1: zero low bits expose the length itself
        for (int f = 0; f < 4; f++) send(32'h0000_1000, f[0], f[1], "R1");
        idle(2);

        // R3: low bits 2..7 with a constant field force the carry
        for (int lo = 0; lo < 8; lo++)
            for (int f = 0; f < 4; f++)
                send(32'h1234_5670 | 32'(lo), f[0], f[1], "R3");
        idle(3);

        // R4: all-ones upper field, carry and wrap in the same cycle
        for (int lo = 0; lo < 8; lo++)
            for (int f = 0; f < 4; f++)
                send(32'hFFFF_FFF8 | 32'(lo), f[0], f[1], "R4");
        idle(2);

        // R8: random PCs and flags, with random idle gaps (R7)
        for (int k = 0; k < 2000; k++) begin
            send($urandom, 1'($urandom), 1'($urandom), "R8");
            if (($urandom % 8) == 0) idle(1 + $urandom % 3);
        end
        idle(4);

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R5 pending results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule